// File: doc/BRIEF.md
# Stochastic Spin-Network Annealer

The block keeps a small network of binary spins, each standing for +1 or -1, joined by a signed, symmetric coupling matrix and pulled by a signed bias per spin. Each accepted step pulse resamples exactly one spin. The block forms the spin's local field from the current state of every other spin and the spin's bias. It scales the field by an inverse temperature, maps the result through a tanh lookup, and compares that value with a pseudo-random sample. The spin becomes +1 when the activation is at least the sample, and -1 otherwise. Spins are visited in a fixed round-robin order.

Software or a controlling state machine first loads couplings and biases. It then issues a start pulse that sets the first and final inverse temperature and the random seed, and then supplies step pulses. After each full sweep the inverse temperature rises by one. When a sweep finishes at the final value, the block raises a done flag and freezes. The Ising energy of the present configuration is always visible at the output, and a host can compare it across runs to pick the lowest-energy result.

Top module: `pspin_sampler`

## Requirements
- R1: After reset, all spins read +1 (spins bit = 1), beta_cur = 0, next_spin = 0, done = 0, every coupling and bias is zero, and so energy = 0.
- R2: With cfg_bias = 0, a cfg_we pulse stores cfg_data in the coupling for the pair (cfg_row, cfg_col) and also in the pair (cfg_col, cfg_row). A later write to either order of the same pair replaces the value. A write with cfg_row = cfg_col is ignored, so the diagonal stays zero. With cfg_bias = 1, the write stores the bias of spin cfg_row, and cfg_col is ignored.
- R3: energy is the signed value -(sum over i<j of W[i][j]*s_i*s_j + sum over i of h[i]*s_i), where s = +1 for spins bit 1 and -1 for bit 0. It follows the registered state with no extra cycle of delay.
- R4: A start pulse, which has priority over any other input, sets all spins to +1, next_spin to 0 and beta_cur to beta_init. It stores beta_max, clears done, and loads the random generator with seed, or with 1 when seed is zero.
- R5: Before the first start after reset, step pulses change nothing.
- R6: On an accepted step, the spin k = next_spin takes the value 1 when T >= r, and 0 otherwise. Here I = h[k] + sum over j of W[k][j]*s_j, and p = beta_cur*I clamped to [-32, 31]. T = trunc(127*p*(1728+p*p) / (8*(1728+9*p*p))), limited to +/-127, with truncation toward zero. r is the low 8 bits of the generator state read as signed. No other spin changes, and next_spin becomes (k+1) mod 8.
- R7: The generator is a 16-bit right-shifting Galois register with feedback mask 0xB400. Each accepted step uses its current value and then advances it by exactly one shift.
- R8: When the update of spin 7 completes a sweep, beta_cur increases by one if it is below the stored beta_max. Otherwise done becomes 1. beta_cur never moves by more than one per sweep, and it never changes except at a sweep end or a start.
- R9: While done = 1, step pulses change no output until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for a coupling or bias |
| cfg_bias | input | 1 | 1 selects the bias file, 0 the coupling matrix |
| cfg_row | input | 3 | First spin index of the write |
| cfg_col | input | 3 | Second spin index (coupling writes only) |
| cfg_data | input | 8 | Signed two's-complement value to store |
| start | input | 1 | Begin a new annealing run |
| beta_init | input | 4 | Inverse temperature for the first sweep |
| beta_max | input | 4 | Inverse temperature of the last sweep |
| seed | input | 16 | Random generator seed |
| step | input | 1 | Request one spin update |
| spins | output | 8 | Spin state, bit i = 1 means spin i is +1 |
| energy | output | 16 | Signed Ising energy of the present state |
| beta_cur | output | 4 | Present inverse temperature |
| next_spin | output | 3 | Index of the spin the next step will update |
| done | output | 1 | The run has finished its last sweep |

## Verification
The embedded properties watch structural limits on every cycle. At most one spin changes per cycle outside a start. The inverse temperature only holds or climbs by one. done rises only as the sweep index wraps. State is frozen while idle or done, and the generator never reaches the all-zero state. Whether a resampled spin takes the right value, whether the energy sum is correct, and whether the write addressing is symmetric can only be shown by the scenarios. These run a reference model of the couplings, the tanh rule and the generator in step with the design, and compare against it. The scenarios cover random couplings, fully saturated positive and negative fields, a run whose initial temperature exceeds its final one, and a restart in the middle of a sweep.

// File: rtl/pspin_pkg.sv
package pspin_pkg;

   // Rational tanh approximation x(27+x^2)/(27+9x^2), x = p/s, scaled by amp.
   function automatic int tanh_code(input int p, input int amp, input int s);
      int num;
      int den;
      int t;
      num = amp * p * (27 * s * s + p * p);
      den = s * (27 * s * s + 9 * p * p);
      t   = num / den;
      if (t > amp)  t = amp;
      if (t < -amp) t = -amp;
      return t;
   endfunction

   // Feedback masks of maximal-length right-shifting Galois registers.
   function automatic logic [31:0] galois_mask(input int width);
      case (width)
         8:       return 32'h0000_00B8;
         16:      return 32'h0000_B400;
         24:      return 32'h00E1_0000;
         32:      return 32'h8020_0003;
         default: return 32'h0;
      endcase
   endfunction

endpackage

// File: rtl/pspin_coupling_regs.sv
module pspin_coupling_regs #(
   parameter int N_SPIN = 8,
   parameter int COEF_W = 8,
   localparam int IDX_W = $clog2(N_SPIN)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic                     bias_sel,
   input  logic [IDX_W-1:0]         row,
   input  logic [IDX_W-1:0]         col,
   input  logic signed [COEF_W-1:0] data,
   output logic signed [COEF_W-1:0] w_o [N_SPIN][N_SPIN],
   output logic signed [COEF_W-1:0] h_o [N_SPIN]
);

   if (N_SPIN < 2) begin : g_bad_n
      $error("pspin_coupling_regs: N_SPIN must be at least 2");
   end
   if (COEF_W < 2) begin : g_bad_w
      $error("pspin_coupling_regs: COEF_W must be at least 2");
   end

   for (genvar i = 0; i < N_SPIN; i++) begin : g_row
      for (genvar j = 0; j < N_SPIN; j++) begin : g_col
         if (i == j) begin : g_diag
            assign w_o[i][j] = '0;
         end else if (i < j) begin : g_upper
            logic signed [COEF_W-1:0] cell_q;
            logic                     hit;
            assign hit = we && !bias_sel &&
                         (((row == IDX_W'(i)) && (col == IDX_W'(j))) ||
                          ((row == IDX_W'(j)) && (col == IDX_W'(i))));
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   cell_q <= '0;
               else if (hit) cell_q <= data;
            end
            assign w_o[i][j] = cell_q;
            assign w_o[j][i] = cell_q;
         end
      end

      logic signed [COEF_W-1:0] bias_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    bias_q <= '0;
         else if (we && bias_sel && row == IDX_W'(i))   bias_q <= data;
      end
      assign h_o[i] = bias_q;
   end

endmodule

// File: rtl/pspin_lfsr.sv
module pspin_lfsr #(
   parameter int LFSR_W = 16,
   parameter int OUT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LFSR_W-1:0] seed,
   input  logic              adv,
   output logic [OUT_W-1:0]  rnd
);

   localparam logic [31:0]       MASK32 = pspin_pkg::galois_mask(LFSR_W);
   localparam logic [LFSR_W-1:0] MASK   = MASK32[LFSR_W-1:0];

   if (MASK32 == 32'h0) begin : g_bad_width
      $error("pspin_lfsr: unsupported LFSR_W");
   end
   if (OUT_W > LFSR_W) begin : g_bad_out
      $error("pspin_lfsr: OUT_W wider than LFSR_W");
   end

   logic [LFSR_W-1:0] state_q;
   logic [LFSR_W-1:0] shifted;

   always_comb begin
      shifted = {1'b0, state_q[LFSR_W-1:1]};
      if (state_q[0]) shifted = shifted ^ MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      state_q <= LFSR_W'(1);
      else if (load)   state_q <= (seed == '0) ? LFSR_W'(1) : seed;
      else if (adv)    state_q <= shifted;
   end

   assign rnd = state_q[OUT_W-1:0];

   // R7: a nonzero state never collapses to zero
   a_r7_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0);

   // R7: the state only moves on a load or an advance
   a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv) |=> $stable(state_q));

endmodule

// File: rtl/pspin_activation.sv
module pspin_activation #(
   parameter int N_SPIN    = 8,
   parameter int COEF_W    = 8,
   parameter int BETA_W    = 4,
   parameter int ACT_W     = 8,
   parameter int LUT_DEPTH = 64,
   localparam int IDX_W    = $clog2(N_SPIN),
   localparam int FIELD_W  = COEF_W + $clog2(N_SPIN) + 1,
   localparam int PROD_W   = FIELD_W + BETA_W + 1,
   localparam int LUT_IW   = $clog2(LUT_DEPTH),
   localparam int HALF     = LUT_DEPTH / 2,
   localparam int SCALE    = LUT_DEPTH / 8,
   localparam int AMP      = (2 ** (ACT_W - 1)) - 1
) (
   input  logic [N_SPIN-1:0]        spins,
   input  logic signed [COEF_W-1:0] w_i [N_SPIN][N_SPIN],
   input  logic signed [COEF_W-1:0] h_i [N_SPIN],
   input  logic [IDX_W-1:0]         idx,
   input  logic [BETA_W-1:0]        beta,
   output logic signed [ACT_W-1:0]  act
);

   if ((LUT_DEPTH < 16) || (LUT_DEPTH % 8 != 0) || (2 ** LUT_IW != LUT_DEPTH)) begin : g_bad_lut
      $error("pspin_activation: LUT_DEPTH must be a power of two of at least 16");
   end
   if (PROD_W > 31) begin : g_bad_prod
      $error("pspin_activation: scaled field too wide");
   end

   logic signed [ACT_W-1:0] lut [LUT_DEPTH];
   for (genvar k = 0; k < LUT_DEPTH; k++) begin : g_lut
      localparam int CODE = pspin_pkg::tanh_code(k - HALF, AMP, SCALE);
      assign lut[k] = ACT_W'(CODE);
   end

   logic signed [FIELD_W-1:0] field;
   logic signed [FIELD_W-1:0] term;
   logic signed [PROD_W-1:0]  prod;
   logic [LUT_IW-1:0]         lut_idx;
   int                        pclamp;

   always_comb begin
      field = FIELD_W'(h_i[idx]);
      for (int j = 0; j < N_SPIN; j++) begin
         term = FIELD_W'(w_i[idx][j]);
         if (spins[j]) field = field + term;
         else          field = field - term;
      end
   end

   always_comb begin
      prod   = field * $signed({1'b0, beta});
      pclamp = int'(prod);
      if (pclamp > HALF - 1) pclamp = HALF - 1;
      if (pclamp < -HALF)    pclamp = -HALF;
      lut_idx = LUT_IW'(pclamp + HALF);
   end

   assign act = lut[lut_idx];

endmodule

// File: rtl/pspin_energy.sv
module pspin_energy #(
   parameter int N_SPIN = 8,
   parameter int COEF_W = 8,
   parameter int EN_W   = 16,
   localparam int SUM_W = EN_W + 2
) (
   input  logic [N_SPIN-1:0]        spins,
   input  logic signed [COEF_W-1:0] w_i [N_SPIN][N_SPIN],
   input  logic signed [COEF_W-1:0] h_i [N_SPIN],
   output logic signed [EN_W-1:0]   energy
);

   localparam int E_MAX = (N_SPIN * (N_SPIN - 1) / 2 + N_SPIN) * (2 ** (COEF_W - 1));

   if (E_MAX >= 2 ** (EN_W - 1)) begin : g_bad_en
      $error("pspin_energy: EN_W too narrow for the energy range");
   end

   logic signed [SUM_W-1:0] pair_sum;
   logic signed [SUM_W-1:0] bias_sum;
   logic signed [SUM_W-1:0] ext;

   // Full double sum over i != j counts every pair twice; halve it.
   always_comb begin
      pair_sum = '0;
      bias_sum = '0;
      for (int i = 0; i < N_SPIN; i++) begin
         ext = SUM_W'(h_i[i]);
         if (spins[i]) bias_sum = bias_sum + ext;
         else          bias_sum = bias_sum - ext;
         for (int j = 0; j < N_SPIN; j++) begin
            ext = SUM_W'(w_i[i][j]);
            if (spins[i] == spins[j]) pair_sum = pair_sum + ext;
            else                      pair_sum = pair_sum - ext;
         end
      end
   end

   logic signed [SUM_W-1:0] total;
   assign total  = -((pair_sum >>> 1) + bias_sum);
   assign energy = EN_W'(total);

endmodule

// File: rtl/pspin_sampler.sv
module pspin_sampler #(
   parameter int N_SPIN    = 8,
   parameter int COEF_W    = 8,
   parameter int BETA_W    = 4,
   parameter int ACT_W     = 8,
   parameter int LUT_DEPTH = 64,
   parameter int LFSR_W    = 16,
   parameter int EN_W      = 16,
   localparam int IDX_W    = $clog2(N_SPIN)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic                     cfg_bias,
   input  logic [IDX_W-1:0]         cfg_row,
   input  logic [IDX_W-1:0]         cfg_col,
   input  logic [COEF_W-1:0]        cfg_data,
   input  logic                     start,
   input  logic [BETA_W-1:0]        beta_init,
   input  logic [BETA_W-1:0]        beta_max,
   input  logic [LFSR_W-1:0]        seed,
   input  logic                     step,
   output logic [N_SPIN-1:0]        spins,
   output logic [EN_W-1:0]          energy,
   output logic [BETA_W-1:0]        beta_cur,
   output logic [IDX_W-1:0]         next_spin,
   output logic                     done
);

   if (2 ** IDX_W != N_SPIN) begin : g_bad_n
      $error("pspin_sampler: N_SPIN must be a power of two");
   end
   if (ACT_W > LFSR_W) begin : g_bad_act
      $error("pspin_sampler: ACT_W must not exceed LFSR_W");
   end

   logic signed [COEF_W-1:0] w_mat [N_SPIN][N_SPIN];
   logic signed [COEF_W-1:0] h_vec [N_SPIN];
   logic signed [ACT_W-1:0]  act;
   logic [ACT_W-1:0]         rnd;
   logic signed [EN_W-1:0]   en_s;

   logic [N_SPIN-1:0] spins_q;
   logic [IDX_W-1:0]  idx_q;
   logic [BETA_W-1:0] beta_q;
   logic [BETA_W-1:0] bmax_q;
   logic              running_q;
   logic              done_q;
   logic              accept;
   logic              sweep_end;

   assign accept    = step && running_q && !done_q && !start;
   assign sweep_end = (idx_q == IDX_W'(N_SPIN - 1));

   pspin_coupling_regs #(.N_SPIN(N_SPIN), .COEF_W(COEF_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .bias_sel (cfg_bias),
      .row      (cfg_row),
      .col      (cfg_col),
      .data     ($signed(cfg_data)),
      .w_o      (w_mat),
      .h_o      (h_vec)
   );

   pspin_activation #(
      .N_SPIN(N_SPIN), .COEF_W(COEF_W), .BETA_W(BETA_W),
      .ACT_W(ACT_W), .LUT_DEPTH(LUT_DEPTH)
   ) u_act (
      .spins (spins_q),
      .w_i   (w_mat),
      .h_i   (h_vec),
      .idx   (idx_q),
      .beta  (beta_q),
      .act   (act)
   );

   pspin_lfsr #(.LFSR_W(LFSR_W), .OUT_W(ACT_W)) u_rng (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .seed  (seed),
      .adv   (accept),
      .rnd   (rnd)
   );

   pspin_energy #(.N_SPIN(N_SPIN), .COEF_W(COEF_W), .EN_W(EN_W)) u_energy (
      .spins  (spins_q),
      .w_i    (w_mat),
      .h_i    (h_vec),
      .energy (en_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spins_q   <= '1;
         idx_q     <= '0;
         beta_q    <= '0;
         bmax_q    <= '0;
         running_q <= 1'b0;
         done_q    <= 1'b0;
      end else if (start) begin
         spins_q   <= '1;
         idx_q     <= '0;
         beta_q    <= beta_init;
         bmax_q    <= beta_max;
         running_q <= 1'b1;
         done_q    <= 1'b0;
      end else if (accept) begin
         spins_q[idx_q] <= (act >= $signed(rnd));
         if (sweep_end) begin
            idx_q <= '0;
            if (beta_q < bmax_q) beta_q <= beta_q + BETA_W'(1);
            else                 done_q <= 1'b1;
         end else begin
            idx_q <= idx_q + IDX_W'(1);
         end
      end
   end

   assign spins     = spins_q;
   assign energy    = en_s;
   assign beta_cur  = beta_q;
   assign next_spin = idx_q;
   assign done      = done_q;

   // R6: outside a start, at most one spin changes per cycle
   a_r6_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($countones(spins_q ^ $past(spins_q)) <= 1));

   // R8: beta only holds or rises by one outside a start
   a_r8_beta_ramp: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ((beta_q == $past(beta_q)) || (beta_q == $past(beta_q) + BETA_W'(1))));

   // R8: done rises only as a sweep wraps back to spin 0
   a_r8_done_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> (idx_q == '0));

   // R5: before any start, the state is frozen
   a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!running_q && !start) |=> ($stable(spins_q) && $stable(idx_q) && $stable(beta_q)));

   // R9: once done, nothing moves until the next start
   a_r9_done_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !start) |=> ($stable(spins_q) && $stable(idx_q) && $stable(beta_q) && done_q));

endmodule

// File: tb/pspin_sampler_bench.sv
module pspin_sampler_bench;

   typedef struct packed {
      logic [7:0]  sp;
      logic [15:0] en;
      logic [3:0]  be;
      logic [2:0]  nx;
      logic        dn;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_bias = 1'b0;
   logic [2:0]  cfg_row = '0;
   logic [2:0]  cfg_col = '0;
   logic [7:0]  cfg_data = '0;
   logic        start = 1'b0;
   logic [3:0]  beta_init = '0;
   logic [3:0]  beta_max = '0;
   logic [15:0] seed = '0;
   logic        step = 1'b0;
   logic [7:0]  spins;
   logic [15:0] energy;
   logic [3:0]  beta_cur;
   logic [2:0]  next_spin;
   logic        done;

   int checks = 0;
   int failures = 0;

   exp_t  expq[$];
   string tagq[$];

   // reference model
   int          mw [8][8];
   int          mh [8];
   logic [7:0]  ms;
   int          mbeta, mbmax, midx;
   bit          mrun, mdone;
   logic [15:0] mlfsr;

   always #5 clk = ~clk;

   pspin_sampler u_pspin_sampler (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bias(cfg_bias),
      .cfg_row(cfg_row), .cfg_col(cfg_col), .cfg_data(cfg_data),
      .start(start), .beta_init(beta_init), .beta_max(beta_max), .seed(seed),
      .step(step), .spins(spins), .energy(energy), .beta_cur(beta_cur),
      .next_spin(next_spin), .done(done)
   );

   function automatic int sgn(input logic b);
      return b ? 1 : -1;
   endfunction

   function automatic int m_energy();
      int e = 0;
      for (int i = 0; i < 8; i++) begin
         e += mh[i] * sgn(ms[i]);
         for (int j = i + 1; j < 8; j++) e += mw[i][j] * sgn(ms[i]) * sgn(ms[j]);
      end
      return -e;
   endfunction

   function automatic int m_tanh(input int p);
      int t;
      t = (127 * p * (1728 + p * p)) / (8 * (1728 + 9 * p * p));
      if (t > 127)  t = 127;
      if (t < -127) t = -127;
      return t;
   endfunction

   function automatic exp_t snapshot();
      exp_t e;
      e.sp = ms;
      e.en = 16'(m_energy());
      e.be = 4'(mbeta);
      e.nx = 3'(midx);
      e.dn = mdone;
      return e;
   endfunction

   task automatic push(input string tag);
      expq.push_back(snapshot());
      tagq.push_back(tag);
   endtask

   task automatic finish_cycle(input string tag);
      @(posedge clk);
      #1;
      cfg_we = 1'b0;
      start  = 1'b0;
      step   = 1'b0;
      push(tag);
   endtask

   task automatic do_cfg(input bit b, input int r, input int c, input int v, input string tag);
      @(negedge clk);
      cfg_we = 1'b1; cfg_bias = b; cfg_row = 3'(r); cfg_col = 3'(c); cfg_data = 8'(v);
      begin
         logic signed [7:0] sv;
         sv = 8'(v);
         if (b) mh[r] = sv;
         else if (r != c) begin mw[r][c] = sv; mw[c][r] = sv; end
      end
      finish_cycle(tag);
   endtask

   task automatic do_start(input int bi, input int bm, input int sd, input string tag);
      @(negedge clk);
      start = 1'b1; beta_init = 4'(bi); beta_max = 4'(bm); seed = 16'(sd);
      ms = '1; midx = 0; mbeta = bi; mbmax = bm; mrun = 1'b1; mdone = 1'b0;
      mlfsr = (16'(sd) == 16'h0) ? 16'h1 : 16'(sd);
      finish_cycle(tag);
   endtask

   task automatic do_step(input string tag);
      @(negedge clk);
      step = 1'b1;
      if (mrun && !mdone) begin
         int f, p, t, r;
         logic signed [7:0] rb;
         f = mh[midx];
         for (int j = 0; j < 8; j++) f += mw[midx][j] * sgn(ms[j]);
         p = f * mbeta;
         if (p > 31)  p = 31;
         if (p < -32) p = -32;
         t  = m_tanh(p);
         rb = mlfsr[7:0];
         r  = rb;
         ms[midx] = (t >= r);
         mlfsr = mlfsr[0] ? ({1'b0, mlfsr[15:1]} ^ 16'hB400) : {1'b0, mlfsr[15:1]};
         if (midx == 7) begin
            midx = 0;
            if (mbeta < mbmax) mbeta++;
            else mdone = 1'b1;
         end else midx++;
      end
      finish_cycle(tag);
   endtask

   task automatic cmp(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // monitor: pops one expected item per cycle after the design updated
   always @(negedge clk) begin
      if (expq.size() > 0) begin
         exp_t e;
         string t;
         e = expq.pop_front();
         t = tagq.pop_front();
         cmp(t, "spins",     int'(spins),             int'(e.sp));
         cmp(t, "energy",    int'($signed(energy)),   int'($signed(e.en)));
         cmp(t, "beta_cur",  int'(beta_cur),          int'(e.be));
         cmp(t, "next_spin", int'(next_spin),         int'(e.nx));
         cmp(t, "done",      int'(done),              int'(e.dn));
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : driver
      for (int i = 0; i < 8; i++) begin
         mh[i] = 0;
         for (int j = 0; j < 8; j++) mw[i][j] = 0;
      end
      ms = '1; mbeta = 0; mbmax = 0; midx = 0; mrun = 0; mdone = 0; mlfsr = 16'h1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      push("R1 reset state");

      do_step("R5 step before start ignored");
      do_step("R5 second step before start ignored");

      do_cfg(0, 0, 1, 20,  "R2 R3 coupling write");
      do_cfg(0, 1, 0, -4,  "R2 reversed pair overwrites");
      do_cfg(0, 3, 3, 100, "R2 diagonal write ignored");
      do_cfg(1, 2, 5, 10,  "R2 R3 bias write, col ignored");

      for (int i = 0; i < 8; i++)
         for (int j = i + 1; j < 8; j++)
            do_cfg(0, j, i, ((i * 37 + j * 23) % 61) - 30, "R2 R3 pattern coupling");
      for (int i = 0; i < 8; i++)
         do_cfg(1, i, 7 - i, ((i * 19) % 41) - 20, "R2 R3 pattern bias");

      do_start(0, 3, 16'hACE1, "R4 start run 1");
      for (int k = 0; k < 32; k++) do_step("R6 R7 R8 annealed sweep");
      for (int k = 0; k < 3; k++)  do_step("R9 steps after done ignored");

      do_start(0, 1, 5, "R4 start run 2");
      for (int k = 0; k < 5; k++) do_step("R6 partial sweep");
      do_start(2, 2, 16'h0042, "R4 restart mid sweep");
      for (int k = 0; k < 8; k++) do_step("R6 R8 single sweep");

      for (int i = 0; i < 8; i++)
         for (int j = i + 1; j < 8; j++) do_cfg(0, i, j, 60, "R3 ferromagnetic load");
      for (int i = 0; i < 8; i++) do_cfg(1, i, 0, 50, "R3 positive bias load");
      do_start(15, 15, 0, "R4 R7 zero seed maps to one");
      for (int k = 0; k < 8; k++) do_step("R6 saturated positive field stays +1");
      do_step("R9 ignored after done");

      for (int i = 0; i < 8; i++)
         for (int j = i + 1; j < 8; j++) do_cfg(0, i, j, 0, "R2 clear coupling");
      for (int i = 0; i < 8; i++) do_cfg(1, i, 0, -128, "R2 negative bias load");
      do_start(15, 15, 16'h1234, "R4 start negative run");
      for (int k = 0; k < 8; k++) do_step("R6 saturated negative field");

      do_start(6, 2, 16'hBEEF, "R4 start with beta_init above beta_max");
      for (int k = 0; k < 8; k++) do_step("R8 no increment above max");
      do_step("R9 ignored after done");

      repeat (3) @(posedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule